// File: doc/BRIEF.md
# Four-Bit GPIO Register Bank

This block is the register file and pin logic behind a four-bit bidirectional port. A separate serial protocol engine decodes bus transactions and hands this block a two-bit register index, together with a write strobe carrying a data byte or a read strobe. The block holds the drive value, the per-pin inversion mask and the per-pin direction. It turns these into output-data and output-enable signals for an external pad. It returns a byte of read data for the selected index.

The pins pass through a multi-flop synchronizer. The synchronized levels are captured into the read-data register on the read strobe, which the protocol engine issues on the acknowledge edge just before it shifts the byte out. Input-port reads apply the inversion mask and show the pin levels whatever the pin direction. Drive-register reads return the stored flip-flop value, not what is on the pin.

Top module: `gpio4_regbank`

## Requirements
- R1: After reset, pin_oe is 0000 and pin_out is 0000. Reads return 0xFF at index 1 (drive), 0x00 at index 2 (inversion) and 0xFF at index 3 (direction). rd_data itself resets to 0x00.
- R2: A write strobe at index 1, 2 or 3 stores wr_data[3:0] in that register at the clock edge. A later read of the same index returns those four bits in rd_data[3:0].
- R3: wr_data[7:4] is ignored. The upper nibble always reads 1111 at indices 0, 1 and 3 and 0000 at index 2.
- R4: A write strobe at index 0 (input port) changes no register and no pin output.
- R5: When direction bit n is 1, pin n is an input: pin_oe[n]=0 and pin_out[n]=0, whatever the drive bit. When direction bit n is 0, pin_oe[n]=1 and pin_out[n] equals drive bit n. The pin outputs follow a write from the next clock edge.
- R6: A read at index 1 returns the stored drive bits even when pin_in shows different levels.
- R7: A read at index 0 returns, in rd_data[3:0], the synchronized pin levels XOR the inversion mask. This holds for every pin, whether it is set as input or output.
- R8: pin_in passes through two flops before capture. A read strobe at the second clock edge after a pin change returns the old level. A read strobe at the third edge returns the new level.
- R9: rd_data changes only at the clock edge where rd_en is high. It holds its value, including a captured input level, until the next read strobe.
- R10: If a read and a write strobe hit the same index in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_idx | input | 2 | Register index: 0 input, 1 drive, 2 inversion, 3 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe; captures read data at this edge |
| rd_data | output | 8 | Read data byte, held between strobes |
| pin_in | input | 4 | Pin levels from the pad, asynchronous |
| pin_out | output | 4 | Output data to the pad |
| pin_oe | output | 4 | Output enable to the pad, 1 drives |

## Verification
The hardest case to reach from the ports is the exact synchronizer window. A read strobe must land exactly one edge too early and then exactly on time after a pin change. Directed stimulus changes pin_in on a falling edge and then strobes reads at the second and third rising edges, checking the old and then the new level. Constrained-random traffic then mixes writes and reads at every index with random upper data bits and random pin patterns. Driven pins are often set opposite to their drive bits, so input-port and drive reads can be told apart.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
    localparam int PORT_W = 4;
    localparam int BUS_W  = 8;
    localparam int SYNC_N = 2;

    typedef enum logic [1:0] {
        IDX_PINS   = 2'd0,
        IDX_DRIVE  = 2'd1,
        IDX_INVERT = 2'd2,
        IDX_DIR    = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [PORT_W-1:0] drive;
        logic [PORT_W-1:0] invert;
        logic [PORT_W-1:0] dir;
    } ctl_regs_t;

    localparam logic [BUS_W-1:0] RST_DRIVE  = '1;
    localparam logic [BUS_W-1:0] RST_INVERT = '0;
    localparam logic [BUS_W-1:0] RST_DIR    = '1;
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
    import gpio4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        reg_idx,
    input  logic [PORT_W-1:0] wr_bits,
    output ctl_regs_t         regs
);
    ctl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (reg_idx_e'(reg_idx))
                IDX_DRIVE:  regs_d.drive  = wr_bits;
                IDX_INVERT: regs_d.invert = wr_bits;
                IDX_DIR:    regs_d.dir    = wr_bits;
                default:    regs_d        = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.drive  <= RST_DRIVE[PORT_W-1:0];
            regs_q.invert <= RST_INVERT[PORT_W-1:0];
            regs_q.dir    <= RST_DIR[PORT_W-1:0];
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/gpio4_rdport.sv
module gpio4_rdport
    import gpio4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        reg_idx,
    input  logic [PORT_W-1:0] pins_sync,
    input  ctl_regs_t         regs,
    output logic [BUS_W-1:0]  rd_data
);
    localparam int UP_W = BUS_W - PORT_W;

    logic [BUS_W-1:0] rd_d, rd_q;
    logic [BUS_W-1:0] sel_val;

    always_comb begin
        case (reg_idx_e'(reg_idx))
            IDX_PINS:   sel_val = {{UP_W{1'b1}}, pins_sync ^ regs.invert};
            IDX_DRIVE:  sel_val = {RST_DRIVE[BUS_W-1:PORT_W], regs.drive};
            IDX_INVERT: sel_val = {RST_INVERT[BUS_W-1:PORT_W], regs.invert};
            default:    sel_val = {RST_DIR[BUS_W-1:PORT_W], regs.dir};
        endcase
        rd_d = rd_en ? sel_val : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/gpio4_regbank.sv
module gpio4_regbank
    import gpio4_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_idx,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    ctl_regs_t         regs;
    logic [PORT_W-1:0] pins_sync;
    logic              unused_hi;

    assign unused_hi = ^wr_data[BUS_W-1:PORT_W];

    gpio4_sync #(.W(PORT_W), .STAGES(SYNC_N)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pins_sync)
    );

    gpio4_regs regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_idx (reg_idx),
        .wr_bits (wr_data[PORT_W-1:0]),
        .regs    (regs)
    );

    gpio4_rdport rdport_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .reg_idx   (reg_idx),
        .pins_sync (pins_sync),
        .regs      (regs),
        .rd_data   (rd_data)
    );

    always_comb begin
        pin_oe  = ~regs.dir;
        pin_out = regs.drive & ~regs.dir;
    end
endmodule

// File: rtl/gpio4_regbank_chk.sv
module gpio4_regbank_chk
    import gpio4_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        reg_idx,
    input logic              wr_en,
    input logic [BUS_W-1:0]  wr_data,
    input logic              rd_en,
    input logic [BUS_W-1:0]  rd_data,
    input logic [PORT_W-1:0] pin_in,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_oe
);
    AST_DIR_WRITE_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == 2'd3) |=> (pin_oe == ~$past(wr_data[PORT_W-1:0]))); // R2
    AST_INPUT_PIN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0)); // R5
    AST_PINS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out))); // R4
    AST_PADS_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(pin_oe) && $stable(pin_out))); // R5
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rd_data)); // R9
    AST_PINS_UPPER_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == 2'd0) |=> (rd_data[BUS_W-1:PORT_W] == '1)); // R3
    AST_INVERT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_idx == 2'd2) |=> (rd_data[BUS_W-1:PORT_W] == '0)); // R3

    logic unused_chk;
    assign unused_chk = ^pin_in;
endmodule

bind gpio4_regbank gpio4_regbank_chk chk_i (.*);

// File: tb/gpio4_regbank_tb_top.sv
`timescale 1ns/1ps
module gpio4_regbank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] pin_in = 4'hF;
    logic [3:0] pin_out;
    logic [3:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0] m_drive = 4'hF;
    logic [3:0] m_inv   = 4'h0;
    logic [3:0] m_dir   = 4'hF;

    always #2.5 clk = ~clk;

    gpio4_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [7:0] exp_rd(input logic [1:0] idx, input logic [3:0] pins);
        case (idx)
            2'd0:    return {4'hF, pins ^ m_inv};
            2'd1:    return {4'hF, m_drive};
            2'd2:    return {4'h0, m_inv};
            default: return {4'hF, m_dir};
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic chk_pads(input string req);
        chk(req, {4'h0, pin_oe}, {4'h0, ~m_dir});
        chk(req, {4'h0, pin_out}, {4'h0, m_drive & ~m_dir});
    endtask

    task automatic do_write(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (idx)
            2'd1: m_drive = d[3:0];
            2'd2: m_inv   = d[3:0];
            2'd3: m_dir   = d[3:0];
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [1:0] idx, input string req);
        logic [7:0] e;
        @(negedge clk);
        reg_idx = idx; rd_en = 1'b1;
        e = exp_rd(idx, pin_in);
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, e);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk("R1 rd_data reset", rd_data, 8'h00);
        chk_pads("R1 pads reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        do_read(2'd1, "R1 drive reset");
        do_read(2'd2, "R1 invert reset");
        do_read(2'd3, "R1 dir reset");

        // R2 R3: writes with dirty upper bits
        do_write(2'd1, 8'h3A);
        do_read(2'd1, "R2 R3 drive readback");
        do_write(2'd3, 8'hC5);
        chk_pads("R5 after dir write");
        do_read(2'd3, "R2 R3 dir readback");
        do_write(2'd2, 8'hF6);
        do_read(2'd2, "R2 R3 invert readback");

        // R4: write to input index is ignored
        do_write(2'd0, 8'h00);
        chk_pads("R4 pads unchanged");
        do_read(2'd1, "R4 drive unchanged");
        do_read(2'd2, "R4 invert unchanged");
        do_read(2'd3, "R4 dir unchanged");

        // R6 R7: all driven, pins opposite to drive
        do_write(2'd3, 8'h00);
        do_write(2'd1, 8'h05);
        do_write(2'd2, 8'h00);
        chk_pads("R5 all outputs");
        @(negedge clk); pin_in = 4'hA;
        repeat (3) @(negedge clk);
        do_read(2'd1, "R6 drive not pin");
        do_read(2'd0, "R7 pins on outputs");
        do_write(2'd2, 8'h09);
        do_read(2'd0, "R7 inverted pins");

        // R8: synchronizer window
        pin_in = 4'h0;
        repeat (3) @(negedge clk);
        pin_in = 4'hF;
        @(negedge clk);
        reg_idx = 2'd0; rd_en = 1'b1;
        @(negedge clk);
        chk("R8 old level at second edge", rd_data, {4'hF, 4'h0 ^ m_inv});
        @(negedge clk);
        rd_en = 1'b0;
        chk("R8 new level at third edge", rd_data, {4'hF, 4'hF ^ m_inv});

        // R9: held data ignores later pin changes
        held = rd_data;
        pin_in = 4'h3;
        repeat (4) @(negedge clk);
        chk("R9 rd_data held", rd_data, held);

        // R10: same-cycle read and write
        @(negedge clk);
        reg_idx = 2'd2; wr_data = 8'h0C; wr_en = 1'b1; rd_en = 1'b1;
        held = exp_rd(2'd2, pin_in);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; m_inv = 4'hC;
        chk("R10 old contents", rd_data, held);
        do_read(2'd2, "R10 new contents");

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] idx;
            idx = 2'($urandom);
            pin_in = 4'($urandom);
            repeat (3) @(negedge clk);
            if ($urandom % 2 == 0) begin
                do_write(idx, 8'($urandom));
                chk_pads("R5 random pads");
            end else begin
                do_read(idx, idx == 2'd0 ? "R7 random input read" : "R2 random readback");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule